// File: doc/BRIEF.md
# Flag Handshake Clock-Domain Link

This block carries one parallel word at a time from a transmit clock domain to a receive clock domain. The two clocks are unrelated. The sender offers a word and raises its ready line. The link registers the word and raises an availability flag in the transmit domain. The receive domain watches a synchronized copy of that flag. When it sees the flag high, it captures the held word, strobes valid, and sets an acknowledge register.

The acknowledge crosses back into the transmit domain and clears the flag. Once the receive side sees the flag low, it drops its acknowledge. When the dropped acknowledge reaches the transmit side, the link accepts a new word.

While any part of this loop is in flight, the transmit side reports busy. Further ready edges are discarded during that time. The held word stays frozen throughout, so the receive side can sample it without a multi-bit synchronizer.

Top module: `flag_cdc_link`

## Requirements
- R1: After both synchronous active-low resets have been held for at least four cycles of their own clocks, `tx_busy` is 0 and `rx_valid` is 0.
- R2: A 0-to-1 transition of `tx_ready`, sampled on a `tx_clk` edge while `tx_busy` is 0, accepts the `tx_data` value at that edge. `tx_busy` reads 1 from the next `tx_clk` cycle.
- R3: Every accepted word appears once on `rx_data` while `rx_valid` is 1. Words appear in the order they were accepted.
- R4: `rx_valid` is never high in two consecutive `rx_clk` cycles. There is exactly one strobe per accepted word.
- R5: A 0-to-1 transition of `tx_ready` while `tx_busy` is 1 is ignored. No extra word is delivered, and the word in flight is not altered.
- R6: Changes on `tx_data` after acceptance do not affect the delivered word.
- R7: `tx_busy` returns to 0 only after the word has been delivered and the acknowledge loop has closed. After that, a new word can be accepted.
- R8: Transfers are lossless and free of duplicates for equal clocks, for a faster transmit clock and for a faster receive clock.
- R9: Acceptance is edge-triggered. A `tx_ready` held high across the end of a transfer does not start another transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit domain clock |
| tx_rst_n | input | 1 | Transmit domain synchronous reset, active low |
| tx_data | input | DATA_W | Word offered by the sender |
| tx_ready | input | 1 | Request; its rising edge offers `tx_data` |
| tx_busy | output | 1 | High while a transfer or its acknowledge loop is pending |
| rx_clk | input | 1 | Receive domain clock |
| rx_rst_n | input | 1 | Receive domain synchronous reset, active low |
| rx_data | output | DATA_W | Last delivered word |
| rx_valid | output | 1 | One-cycle strobe marking a new word on `rx_data` |

## Verification
A flag that clears early or an acknowledge that drops before the flag falls shows up at the ports within one handshake round trip. The symptom is a repeated or skipped word on `rx_data`, or a `tx_busy` that falls before delivery. A frozen loop shows up as `tx_busy` stuck high, which stalls the next word. The bench compares every delivered word, as it arrives, against an arithmetic sequence for each clock ratio. It also counts deliveries after the link has gone idle, so a duplicate or loss is caught before the next configuration begins.

// File: rtl/flag_cdc_pkg.sv
// Shared types for the flag handshake link.
package flag_cdc_pkg;
    // State of the receive-side acknowledge register.
    typedef enum logic {
        ACK_IDLE = 1'b0,
        ACK_HELD = 1'b1
    } ack_state_e;
endpackage

// File: rtl/flag_cdc_sync.sv
// Multi-flop synchronizer for one level signal.
// Assumes: the input is a register output from another domain, and STAGES >= 2.
module flag_cdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the foreign-domain level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later flops give the first one time to settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/flag_cdc_tx.sv
// Transmit side: detects the ready edge, holds the word, owns the availability
// flag, and clears the flag once the synchronized acknowledge arrives.
// Assumes: ack_in is a register output of the receive domain.
module flag_cdc_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ready,
    input  logic              ack_in,
    output logic              busy,
    output logic              flag_out,
    output logic [DATA_W-1:0] word_out
);
    logic ack_seen;
    logic ready_q;
    logic accept;

    flag_cdc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_in),
        .q     (ack_seen)
    );

    // A new word is taken only on a ready edge with the whole loop idle.
    assign accept = ready && !ready_q && !flag_out && !ack_seen;
    assign busy   = flag_out || ack_seen;

    // Flag set on acceptance, cleared by the returning acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= 1'b0;
            flag_out <= 1'b0;
            word_out <= '0;
        end else begin
            ready_q <= ready;
            if (accept) begin
                flag_out <= 1'b1;
                word_out <= data_in;
            end else if (flag_out && ack_seen) begin
                flag_out <= 1'b0;
            end
        end
    end

    // R2: the flag stays up until the acknowledge is seen.
    a_r2_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        flag_out && !ack_seen |=> flag_out);
    // R6: the held word is frozen while busy.
    a_r6_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_out));
    // R5: a new transfer never starts while the acknowledge is pending.
    a_r5_no_set_while_acked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_out) |-> $past(!ack_seen));
    // R7: the flag clears only in response to the acknowledge.
    a_r7_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_out) |-> $past(ack_seen));
endmodule

// File: rtl/flag_cdc_rx.sv
// Receive side: polls the synchronized flag, captures the held word once,
// raises the acknowledge, and drops it when the flag is seen low.
// Assumes: word_in is stable whenever flag_in has been high long enough to pass
// through the synchronizer.
module flag_cdc_rx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_in,
    input  logic [DATA_W-1:0] word_in,
    output logic              ack_out,
    output logic [DATA_W-1:0] data_out,
    output logic              valid
);
    import flag_cdc_pkg::*;

    logic       flag_seen;
    ack_state_e ack_st;

    flag_cdc_sync #(.STAGES(SYNC_STAGES)) u_flag_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flag_in),
        .q     (flag_seen)
    );

    // Capture on flag high; release the acknowledge after the flag falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_st   <= ACK_IDLE;
            data_out <= '0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (ack_st)
                ACK_IDLE: if (flag_seen) begin
                    data_out <= word_in;
                    valid    <= 1'b1;
                    ack_st   <= ACK_HELD;
                end
                ACK_HELD: if (!flag_seen) begin
                    ack_st <= ACK_IDLE;
                end
                default: ack_st <= ACK_IDLE;
            endcase
        end
    end

    assign ack_out = (ack_st == ACK_HELD);

    // R4: the strobe lasts a single cycle.
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R3: a word is delivered only while the flag is seen high.
    a_r3_capture_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> flag_seen);
    // R3: the acknowledge holds while the flag is still up.
    a_r3_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out && flag_seen |=> ack_out);
    // R5: no second capture while the acknowledge is held.
    a_r5_no_recapture: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |=> !valid);
endmodule

// File: rtl/flag_cdc_link.sv
// Top of the flag handshake link: joins the transmit and receive halves.
// Assumes: the clocks are unrelated, and each domain has its own synchronous reset.
module flag_cdc_link #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              tx_busy,
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    logic              avail_flag;
    logic              rx_ack;
    logic [DATA_W-1:0] held_word;

    flag_cdc_tx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
        .clk      (tx_clk),
        .rst_n    (tx_rst_n),
        .data_in  (tx_data),
        .ready    (tx_ready),
        .ack_in   (rx_ack),
        .busy     (tx_busy),
        .flag_out (avail_flag),
        .word_out (held_word)
    );

    flag_cdc_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk      (rx_clk),
        .rst_n    (rx_rst_n),
        .flag_in  (avail_flag),
        .word_in  (held_word),
        .ack_out  (rx_ack),
        .data_out (rx_data),
        .valid    (rx_valid)
    );
endmodule

// File: tb/flag_cdc_link_bench.sv
module flag_cdc_link_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int WORDS      = 10;
    localparam int CFGS       = 6;

    int tx_half = CLK_PERIOD / 2;
    int rx_half = CLK_PERIOD / 2;
    logic tx_clk = 1'b0, rx_clk = 1'b0;
    logic tx_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic [DATA_W-1:0] tx_data = '0;
    logic tx_ready = 1'b0;
    logic tx_busy, rx_valid;
    logic [DATA_W-1:0] rx_data;

    int checks = 0, fails = 0;
    int cur_cfg = 0, rx_cnt = 0;
    bit mon_en = 1'b0;
    logic prev_valid = 1'b0;

    flag_cdc_link #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_flag_cdc_link (
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_busy(tx_busy),
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_data(rx_data),
        .rx_valid(rx_valid)
    );

    initial forever begin #(tx_half); tx_clk = ~tx_clk; end
    initial forever begin #(rx_half); rx_clk = ~rx_clk; end

    function automatic logic [DATA_W-1:0] word_of(int cfg, int k);
        return DATA_W'(cfg * 37 + k * 11 + 3);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Receive monitor: order, value and strobe width (R3, R4).
    always @(negedge rx_clk) begin
        if (mon_en) begin
            if (rx_valid && prev_valid) check(1'b0, "R4", 2, 1);
            if (rx_valid) begin
                check(rx_data == word_of(cur_cfg, rx_cnt), "R3",
                      rx_data, word_of(cur_cfg, rx_cnt));
                rx_cnt++;
            end
        end
        prev_valid = rx_valid;
    end

    task automatic send(int cfg, int k);
        @(negedge tx_clk);
        while (tx_busy) @(negedge tx_clk);
        tx_data  = word_of(cfg, k);
        tx_ready = 1'b1;
        @(negedge tx_clk);
        check(tx_busy == 1'b1, "R2", tx_busy, 1);
        tx_data = ~word_of(cfg, k);            // R6: post-accept change
        if (k % 2 == 0) begin
            tx_ready = 1'b0;
            @(negedge tx_clk);
            if (tx_busy) begin                  // R5: edge while busy
                tx_ready = 1'b1;
                tx_data  = 8'hA5;
                @(negedge tx_clk);
                tx_ready = 1'b0;
            end
            while (tx_busy) @(negedge tx_clk);
        end else begin
            while (tx_busy) @(negedge tx_clk);  // R9: ready held high
            @(negedge tx_clk);
            check(tx_busy == 1'b0, "R9", tx_busy, 0);
            tx_ready = 1'b0;
        end
        check(rx_cnt == k + 1, "R7", rx_cnt, k + 1);
    endtask

    initial begin
        for (int cfg = 0; cfg < CFGS; cfg++) begin
            case (cfg)
                0: begin tx_half = 5;  rx_half = 5;  end
                1: begin tx_half = 5;  rx_half = 17; end
                2: begin tx_half = 17; rx_half = 5;  end
                3: begin tx_half = 5;  rx_half = 41; end
                4: begin tx_half = 37; rx_half = 6;  end
                default: begin tx_half = 7; rx_half = 11; end
            endcase
            mon_en   = 1'b0;
            tx_rst_n = 1'b0;
            rx_rst_n = 1'b0;
            tx_ready = 1'b0;
            repeat (6) @(negedge tx_clk);
            repeat (6) @(negedge rx_clk);
            check(tx_busy == 1'b0, "R1", tx_busy, 0);
            check(rx_valid == 1'b0, "R1", rx_valid, 0);
            cur_cfg = cfg;
            rx_cnt  = 0;
            mon_en  = 1'b1;
            @(negedge tx_clk) tx_rst_n = 1'b1;
            @(negedge rx_clk) rx_rst_n = 1'b1;
            for (int k = 0; k < WORDS; k++) send(cfg, k);
            repeat (20) @(negedge rx_clk);
            repeat (20) @(negedge tx_clk);
            check(rx_cnt == WORDS, "R8 R5", rx_cnt, WORDS);
            check(tx_busy == 1'b0, "R7", tx_busy, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule